// File: doc/BRIEF.md
# Serial Control Port with Staged Divider Words

This block is the register side of a three-wire serial control port, running entirely in the system clock domain. A host lowers the active-low select, toggles a serial clock and sends 24 bits on one data line. Those bits carry a read/write flag, a 15-bit address and one data byte. The serial clock, select and data input are brought in through two-flop synchronizers, and edges are found from the synchronized clock. The serial clock must therefore run well below the system clock; the bench uses eight system cycles per serial phase.

A write lands in a byte-wide register file when the select returns high. A read turns the shared data line around for the last eight bits. The line is modelled here as a data output plus an output enable, and the pad that joins it to the input sits outside the block. A static pin chooses the bit order for both the instruction and the data.

Nine registers hold the frequency words of a divider: a 16-bit integer word, a 24-bit first fractional word, a 16-bit second fractional word and a 16-bit auxiliary modulus. Writes to these registers only stage new values. The words the divider actually uses change together, in one cycle, when the integer low byte is written. An output divider select can either follow its register at once or wait for that same commit, and its register holds the bit that makes the choice.

Top module: `sreg_port`

## Requirements
- R1: With `lsb_first`=0 a frame is, in transmit order, the read flag (1 = read), address bits A14 down to A0, then data bits D7 down to D0. Each bit is sampled on a rising serial clock edge while the select is low.
- R2: With `lsb_first`=1 a frame is, in transmit order, address bits A0 up to A14, then the read flag, then data bits D0 up to D7. Read data is returned in the same order.
- R3: A write frame takes effect when the select rises after exactly 24 rising serial clock edges. A frame with fewer or more edges changes no register and no output.
- R4: On a read, the addressed byte is driven on `spi_sdo` one bit per falling serial clock edge during the last eight bit times, with `spi_sdo_oe` high. One system cycle after the synchronized select is high, `spi_sdo_oe` is low.
- R5: Addresses 0x10..0x18 are staged; a read returns the staged value. The active words are `int_word`={0x11,0x10}, `frac1_word`={0x14,0x13,0x12}, `frac2_word`={0x16,0x15} and `mod2_word`={0x18,0x17}, with the higher address as the higher byte. All four change together, and only in the cycle after 0x10 is written.
- R6: Register 0x19 holds the output divider select in bits 6:4 and a buffer option in bit 3. When a write to 0x19 carries bit 3 = 0, `div_sel` takes bits 6:4 at once. When it carries bit 3 = 1, `div_sel` keeps its value until the next write to 0x10, which loads it from the staged bits 6:4.
- R7: Bits 7 and 2:0 of register 0x19 are reserved and always read 0. Addresses at or above `NUM_REGS` (32 by default) ignore writes and read 0x00.
- R8: After reset, register 0x00 reads 0x3C, register 0x01 reads 0xA5, and every other register reads 0x00. All active words and `div_sel` are 0, and `spi_sdo_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_csn | input | 1 | Active-low frame select |
| spi_sdi | input | 1 | Serial data, pad input side of the shared line |
| spi_sdo | output | 1 | Serial read data, pad output side |
| spi_sdo_oe | output | 1 | Pad output enable for read data |
| lsb_first | input | 1 | Bit order: 0 sends the most significant bit first, 1 the least; static during a frame |
| int_word | output | 16 | Active integer word |
| frac1_word | output | 24 | Active first fractional word |
| frac2_word | output | 16 | Active second fractional word |
| mod2_word | output | 16 | Active auxiliary modulus |
| div_sel | output | 3 | Active output divider select |

## Verification
The hardest case to reach is a write to 0x19 with the buffer option set. A later write to 0x10 must then load the divider select in the same cycle as the staged frequency words, while a write with the option clear must bypass the commit. Random traffic is weighted heavily towards addresses 0x10..0x19 with random data bytes, so the option bit flips often between commits and every ordering of staging, option and commit occurs. Directed frames of 20 and 25 bits in both bit orders cover truncated and overlong transfers.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int FRAME_BITS = 24;
  localparam int INSTR_BITS = 16;
  localparam int DATA_BITS  = 8;
  localparam int ADDR_BITS  = 15;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_INSTR = CNT_W'(INSTR_BITS);
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER  = CNT_W'(FRAME_BITS + 1);

  localparam logic [ADDR_BITS-1:0] A_INT_LO  = 15'h10;
  localparam logic [ADDR_BITS-1:0] A_INT_HI  = 15'h11;
  localparam logic [ADDR_BITS-1:0] A_FR1_B0  = 15'h12;
  localparam logic [ADDR_BITS-1:0] A_FR1_B1  = 15'h13;
  localparam logic [ADDR_BITS-1:0] A_FR1_B2  = 15'h14;
  localparam logic [ADDR_BITS-1:0] A_FR2_B0  = 15'h15;
  localparam logic [ADDR_BITS-1:0] A_FR2_B1  = 15'h16;
  localparam logic [ADDR_BITS-1:0] A_MOD_B0  = 15'h17;
  localparam logic [ADDR_BITS-1:0] A_MOD_B1  = 15'h18;
  localparam logic [ADDR_BITS-1:0] A_DIVCTL  = 15'h19;
  localparam logic [DATA_BITS-1:0] DIVCTL_WMASK = 8'h78;
  localparam int DIV_LSB = 4;
  localparam int DIV_W   = 3;
  localparam int DIV_DB_BIT = 3;

  typedef struct packed {
    logic                 rd;
    logic [ADDR_BITS-1:0] addr;
  } instr_t;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic st1, st2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1 <= RST_VAL[g];
        st2 <= RST_VAL[g];
      end else begin
        st1 <= d[g];
        st2 <= st1;
      end
    end
    assign q[g] = st2;
  end
endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
  import sreg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk_s,
  input  logic                 csn_s,
  input  logic                 sdi_s,
  input  logic                 lsb_first,
  output logic [ADDR_BITS-1:0] rd_addr,
  input  logic [DATA_BITS-1:0] rd_data,
  output logic                 wr_en,
  output logic [ADDR_BITS-1:0] wr_addr,
  output logic [DATA_BITS-1:0] wr_data,
  output logic                 sdo,
  output logic                 sdo_oe
);
  logic sclk_q, csn_q;
  logic rise, fall, csn_rise;
  logic [CNT_W-1:0] cnt;
  logic [INSTR_BITS-1:0] sh;
  logic instr_vld, rd_act;
  instr_t instr_q, instr_now;
  logic [DATA_BITS-1:0] rd_sh, data_now;

  function automatic logic [INSTR_BITS-1:0] rev16(input logic [INSTR_BITS-1:0] v);
    for (int i = 0; i < INSTR_BITS; i++) rev16[i] = v[INSTR_BITS-1-i];
  endfunction

  function automatic logic [DATA_BITS-1:0] rev8(input logic [DATA_BITS-1:0] v);
    for (int i = 0; i < DATA_BITS; i++) rev8[i] = v[DATA_BITS-1-i];
  endfunction

  assign rise     = sclk_s & ~sclk_q & ~csn_s;
  assign fall     = ~sclk_s & sclk_q & ~csn_s;
  assign csn_rise = csn_s & ~csn_q;

  assign instr_now = lsb_first ? instr_t'(rev16(sh)) : instr_t'(sh);
  assign data_now  = lsb_first ? rev8(sh[DATA_BITS-1:0]) : sh[DATA_BITS-1:0];
  assign rd_addr   = instr_now.addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
      cnt    <= '0;
      sh     <= '0;
    end else begin
      sclk_q <= sclk_s;
      csn_q  <= csn_s;
      if (csn_s) cnt <= '0;
      else if (rise && cnt != CNT_OVER) cnt <= cnt + 1'b1;
      if (rise) sh <= {sh[INSTR_BITS-2:0], sdi_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_vld <= 1'b0;
      instr_q   <= '0;
      rd_act    <= 1'b0;
      rd_sh     <= '0;
      sdo       <= 1'b0;
      sdo_oe    <= 1'b0;
    end else if (csn_s) begin
      instr_vld <= 1'b0;
      rd_act    <= 1'b0;
      sdo_oe    <= 1'b0;
    end else begin
      if (cnt == CNT_INSTR && !instr_vld) begin
        instr_vld <= 1'b1;
        instr_q   <= instr_now;
        if (instr_now.rd) begin
          rd_act <= 1'b1;
          rd_sh  <= rd_data;
        end
      end
      if (fall && rd_act && cnt >= CNT_INSTR && cnt < CNT_FULL) begin
        sdo_oe <= 1'b1;
        if (lsb_first) begin
          sdo   <= rd_sh[0];
          rd_sh <= {1'b0, rd_sh[DATA_BITS-1:1]};
        end else begin
          sdo   <= rd_sh[DATA_BITS-1];
          rd_sh <= {rd_sh[DATA_BITS-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= csn_rise && instr_vld && !instr_q.rd && cnt == CNT_FULL;
      if (csn_rise) begin
        wr_addr <= instr_q.addr;
        wr_data <= data_now;
      end
    end
  end

  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !sdo_oe) else $error("oe held while deselected"); // R4
  AST_WR_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> csn_s) else $error("write while selected"); // R3
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en) else $error("write pulse too long"); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_OVER) else $error("bit count overrun"); // R3
endmodule

// File: rtl/sreg_file.sv
module sreg_file
  import sreg_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter logic [8*NUM_REGS-1:0] RST_TABLE = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_BITS-1:0] wr_addr,
  input  logic [DATA_BITS-1:0] wr_data,
  input  logic [ADDR_BITS-1:0] rd_addr,
  output logic [DATA_BITS-1:0] rd_data,
  output logic [15:0]          int_o,
  output logic [23:0]          frac1_o,
  output logic [15:0]          frac2_o,
  output logic [15:0]          mod2_o,
  output logic [DIV_W-1:0]     div_sel_o
);
  localparam int AW = $clog2(NUM_REGS);

  function automatic logic [DATA_BITS-1:0] wmask(input int idx);
    return (idx == int'(A_DIVCTL)) ? DIVCTL_WMASK : 8'hFF;
  endfunction

  function automatic logic [DATA_BITS-1:0] rst_byte(input int idx);
    return RST_TABLE[idx*8 +: 8] & wmask(idx);
  endfunction

  logic [DATA_BITS-1:0] regs [NUM_REGS];
  logic wr_hit, commit, div_direct;
  logic [AW-1:0] wr_idx, rd_idx;
  logic [DATA_BITS-1:0] divctl;

  assign wr_hit     = wr_en && (wr_addr < ADDR_BITS'(NUM_REGS));
  assign wr_idx     = wr_addr[AW-1:0];
  assign rd_idx     = rd_addr[AW-1:0];
  assign commit     = wr_en && wr_addr == A_INT_LO;
  assign div_direct = wr_en && wr_addr == A_DIVCTL && !wr_data[DIV_DB_BIT];
  assign divctl     = regs[A_DIVCTL[AW-1:0]];
  assign rd_data    = (rd_addr < ADDR_BITS'(NUM_REGS)) ? regs[rd_idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= rst_byte(i);
    end else if (wr_hit) begin
      regs[wr_idx] <= wr_data & wmask(int'(wr_idx));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_o     <= {rst_byte(int'(A_INT_HI)), rst_byte(int'(A_INT_LO))};
      frac1_o   <= {rst_byte(int'(A_FR1_B2)), rst_byte(int'(A_FR1_B1)), rst_byte(int'(A_FR1_B0))};
      frac2_o   <= {rst_byte(int'(A_FR2_B1)), rst_byte(int'(A_FR2_B0))};
      mod2_o    <= {rst_byte(int'(A_MOD_B1)), rst_byte(int'(A_MOD_B0))};
      div_sel_o <= rst_byte(int'(A_DIVCTL))[DIV_LSB +: DIV_W];
    end else if (commit) begin
      int_o     <= {regs[A_INT_HI[AW-1:0]], wr_data};
      frac1_o   <= {regs[A_FR1_B2[AW-1:0]], regs[A_FR1_B1[AW-1:0]], regs[A_FR1_B0[AW-1:0]]};
      frac2_o   <= {regs[A_FR2_B1[AW-1:0]], regs[A_FR2_B0[AW-1:0]]};
      mod2_o    <= {regs[A_MOD_B1[AW-1:0]], regs[A_MOD_B0[AW-1:0]]};
      div_sel_o <= divctl[DIV_LSB +: DIV_W];
    end else if (div_direct) begin
      div_sel_o <= wr_data[DIV_LSB +: DIV_W];
    end
  end

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(int_o) && $stable(frac1_o) && $stable(frac2_o) && $stable(mod2_o)))
    else $error("active word moved without commit"); // R5
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_DIVCTL && wr_data[DIV_DB_BIT]) |=> $stable(div_sel_o))
    else $error("buffered divider select moved early"); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (divctl & ~DIVCTL_WMASK) == '0) else $error("reserved bit set"); // R7
endmodule

// File: rtl/sreg_port.sv
module sreg_port
  import sreg_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter logic [8*NUM_REGS-1:0] RST_TABLE = {{(NUM_REGS-2){8'h00}}, 8'hA5, 8'h3C}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sclk,
  input  logic        spi_csn,
  input  logic        spi_sdi,
  output logic        spi_sdo,
  output logic        spi_sdo_oe,
  input  logic        lsb_first,
  output logic [15:0] int_word,
  output logic [23:0] frac1_word,
  output logic [15:0] frac2_word,
  output logic [15:0] mod2_word,
  output logic [2:0]  div_sel
);
  logic [2:0] sync_q;
  logic wr_en;
  logic [ADDR_BITS-1:0] wr_addr, rd_addr;
  logic [DATA_BITS-1:0] wr_data, rd_data;

  sreg_sync #(.W(3), .RST_VAL(3'b010)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .d({spi_sdi, spi_csn, spi_sclk}), .q(sync_q));

  sreg_frame frame_i (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sync_q[0]), .csn_s(sync_q[1]), .sdi_s(sync_q[2]),
    .lsb_first(lsb_first),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdo(spi_sdo), .sdo_oe(spi_sdo_oe));

  sreg_file #(.NUM_REGS(NUM_REGS), .RST_TABLE(RST_TABLE)) file_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .int_o(int_word), .frac1_o(frac1_word), .frac2_o(frac2_word),
    .mod2_o(mod2_word), .div_sel_o(div_sel));
endmodule

// File: tb/sreg_port_tb_top.sv
module sreg_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_csn = 1'b1, spi_sdi = 1'b0, lsb_first = 1'b0;
  logic spi_sdo, spi_sdo_oe;
  logic [15:0] int_word, frac2_word, mod2_word;
  logic [23:0] frac1_word;
  logic [2:0] div_sel;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_regs [32];
  logic [15:0] m_int, m_fr2, m_mod;
  logic [23:0] m_fr1;
  logic [2:0] m_div;

  always #10 clk = ~clk;

  sreg_port dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
    .lsb_first(lsb_first), .int_word(int_word), .frac1_word(frac1_word),
    .frac2_word(frac2_word), .mod2_word(mod2_word), .div_sel(div_sel));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_mask(input int a);
    return (a == 25) ? 8'h78 : 8'hFF;
  endfunction

  function automatic logic [7:0] m_read(input logic [14:0] a);
    return (a < 15'd32) ? m_regs[a[4:0]] : 8'h00;
  endfunction

  task automatic m_write(input logic [14:0] a, input logic [7:0] d);
    if (a >= 15'd32) return;
    m_regs[a[4:0]] = d & m_mask(int'(a));
    if (a == 15'd25 && !d[3]) m_div = d[6:4];
    if (a == 15'd16) begin
      m_int = {m_regs[17], m_regs[16]};
      m_fr1 = {m_regs[20], m_regs[19], m_regs[18]};
      m_fr2 = {m_regs[22], m_regs[21]};
      m_mod = {m_regs[24], m_regs[23]};
      m_div = m_regs[25][6:4];
    end
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic xfer(input bit lsb, input bit rd, input logic [14:0] a,
                      input logic [7:0] d, input int nbits,
                      output logic [7:0] q, output bit oe_ok);
    logic [23:0] seq;
    q = 8'h00;
    oe_ok = 1'b1;
    seq = {rd, a, d};
    @(negedge clk);
    lsb_first = lsb;
    half();
    spi_csn = 1'b0;
    half();
    for (int i = 0; i < nbits; i++) begin
      if (i >= 24) spi_sdi = 1'b0;
      else if (!lsb) spi_sdi = seq[23-i];
      else if (i < 15) spi_sdi = a[i];
      else if (i == 15) spi_sdi = rd;
      else spi_sdi = d[i-16];
      half();
      if (i >= 16 && i < 24) begin
        if (lsb) q[i-16] = spi_sdo; else q[23-i] = spi_sdo;
        oe_ok &= (spi_sdo_oe === 1'b1);
      end
      spi_sclk = 1'b1;
      half();
      spi_sclk = 1'b0;
    end
    half();
    spi_csn = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic do_wr(input bit lsb, input logic [14:0] a, input logic [7:0] d);
    logic [7:0] q;
    bit ok;
    xfer(lsb, 1'b0, a, d, 24, q, ok);
    m_write(a, d);
  endtask

  task automatic do_rd(input bit lsb, input logic [14:0] a, input string req);
    logic [7:0] q;
    bit ok;
    xfer(lsb, 1'b1, a, 8'h00, 24, q, ok);
    check(req, {24'h0, q}, {24'h0, m_read(a)});
    check("R4 oe during read", {31'h0, ok}, 32'h1);
    check("R4 oe released", {31'h0, spi_sdo_oe}, 32'h0);
  endtask

  task automatic chk_active(input string req);
    check({req, " int"}, {16'h0, int_word}, {16'h0, m_int});
    check({req, " frac1"}, {8'h0, frac1_word}, {8'h0, m_fr1});
    check({req, " frac2"}, {16'h0, frac2_word}, {16'h0, m_fr2});
    check({req, " mod2"}, {16'h0, mod2_word}, {16'h0, m_mod});
    check({req, " div"}, {29'h0, div_sel}, {29'h0, m_div});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    bit ok;
    void'($urandom(32'd7321));
    for (int i = 0; i < 32; i++) m_regs[i] = 8'h00;
    m_regs[0] = 8'h3C;
    m_regs[1] = 8'hA5;
    m_int = '0; m_fr1 = '0; m_fr2 = '0; m_mod = '0; m_div = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R8 reset state
    chk_active("R8 reset");
    check("R8 oe after reset", {31'h0, spi_sdo_oe}, 32'h0);
    do_rd(1'b0, 15'h0, "R8 reg0 reset");
    do_rd(1'b1, 15'h1, "R8 reg1 reset");
    do_rd(1'b0, 15'h19, "R8 divctl reset");

    // R1 / R2 basic write and read in both orders
    do_wr(1'b0, 15'h03, 8'hC1);
    do_rd(1'b0, 15'h03, "R1 msb write/read");
    do_wr(1'b1, 15'h04, 8'h2D);
    do_rd(1'b1, 15'h04, "R2 lsb write/read");
    do_rd(1'b0, 15'h04, "R1 cross-order read");

    // R5 staging: no change until commit
    do_wr(1'b0, 15'h11, 8'h12);
    do_wr(1'b1, 15'h14, 8'h9A);
    do_wr(1'b0, 15'h18, 8'h77);
    chk_active("R5 staged only");
    do_rd(1'b0, 15'h14, "R5 staged readback");
    do_wr(1'b1, 15'h10, 8'h34);
    chk_active("R5 after commit");

    // R6 buffered vs direct divider select
    do_wr(1'b0, 15'h19, 8'h58);
    chk_active("R6 buffered held");
    do_wr(1'b0, 15'h10, 8'h01);
    chk_active("R6 buffered commit");
    do_wr(1'b1, 15'h19, 8'h30);
    chk_active("R6 direct");

    // R7 reserved bits and unmapped addresses
    do_wr(1'b0, 15'h19, 8'hFF);
    do_rd(1'b0, 15'h19, "R7 reserved read zero");
    do_wr(1'b0, 15'h7FFF, 8'h55);
    do_rd(1'b0, 15'h7FFF, "R7 unmapped read zero");
    do_wr(1'b1, 15'd40, 8'hAA);
    do_rd(1'b1, 15'd8, "R7 unmapped no alias");

    // R3 short and long frames discarded
    xfer(1'b0, 1'b0, 15'h05, 8'hEE, 20, q, ok);
    do_rd(1'b0, 15'h05, "R3 short frame ignored");
    xfer(1'b1, 1'b0, 15'h10, 8'hEE, 25, q, ok);
    chk_active("R3 long frame no commit");
    do_rd(1'b1, 15'h10, "R3 long frame ignored");
    xfer(1'b0, 1'b0, 15'h10, 8'h99, 20, q, ok);
    chk_active("R3 short frame no commit");

    // random traffic, weighted to the staged group
    for (int n = 0; n < 90; n++) begin
      logic [14:0] a;
      int r;
      bit lsb;
      r = $urandom % 10;
      if (r < 7) a = 15'(16 + ($urandom % 10));
      else if (r < 9) a = 15'($urandom % 32);
      else a = 15'h7FFF - 15'($urandom % 4);
      lsb = 1'($urandom % 2);
      if ($urandom % 3 == 0) do_rd(lsb, a, "R1 R2 R7 random read");
      else begin
        do_wr(lsb, a, 8'($urandom));
        chk_active("R5 R6 random");
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule